// File: doc/BRIEF.md
# Deferred Condition Flag Resolver

This block produces the four arithmetic condition flags (negative, zero, overflow, carry) of a processor some time after the instruction that created them. The datapath does not compute flags on every operation. It saves the result word, one source word and a tag naming the kind of operation. When a later instruction needs the flags, the saved triple is presented here and the flags are rebuilt from it. For subtract-type tags the minuend is recovered internally by adding the saved source back onto the result.

Each evaluation request is taken on one rising clock edge. Starting with the next cycle the block holds the flag word in a register and raises a one-cycle strobe. The request carries the previous flag word. The extend bit of that word is passed through untouched. Its zero bit limits the new zero flag when an extended-precision chain is in progress. A tag outside the known set raises a one-cycle error strobe and leaves the flag register as it was.

Top module: `cc_lazy_eval`

## Requirements
- R1: While rst_ni is low and after its release, flags_o is 5'b00000 and valid_o and err_o are 0. A cycle without eval_i leaves flags_o unchanged and keeps valid_o and err_o at 0.
- R2: flags_o bit 3 (N) is result bit 31 and bit 2 (Z) is set when the result is zero. N and Z are never both set by a computed tag. Tag 1 (logic) clears V (bit 1) and C (bit 0).
- R3: Tag 2 (add) sets C when the result is unsigned-below the source. It sets V from bit 31 of (src^res) & ~((res-src)^src).
- R4: Tag 3 (subtract) forms t = res+src. It sets C when t is unsigned-below src and V from bit 31 of (t^res)&(t^src).
- R5: Tag 4 (byte compare) and tag 5 (word compare) apply the R4 rule to the low 8 or 16 bits only. N and V are then taken at bit 7 or bit 15, and upper operand bits have no effect.
- R6: Tag 6 (add with extend) sets C when res <= src. It sets V as in R3 with t = res-src-1.
- R7: Tag 7 (subtract with extend) forms t = res+src+1. It sets C when t <= src and V from bit 31 of (t^res)&(t^src).
- R8: Tag 8 (shift) sets N and Z from the result, sets C when src is nonzero, and clears V.
- R9: With chain_i high and tag 2, 3, 6 or 7, the new Z is the computed Z ANDed with prev_i bit 2.
- R10: Tag 0 (already resolved) copies res_i[3:0] into flags_o[3:0].
- R11: A tag of 9 to 15 makes err_o 1 for one cycle, keeps valid_o at 0 and leaves flags_o unchanged.
- R12: An accepted request updates flags_o on the next rising edge, raises valid_o for that one cycle, and copies prev_i bit 4 (X) into flags_o bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Evaluation request |
| op_i | input | 4 | Deferred operation tag |
| res_i | input | 32 | Saved result word |
| src_i | input | 32 | Saved source word |
| prev_i | input | 5 | Previous flag word {X,N,Z,V,C} |
| chain_i | input | 1 | Extended-precision chain in progress |
| flags_o | output | 5 | Resolved flag word {X,N,Z,V,C} |
| valid_o | output | 1 | One-cycle strobe for an accepted request |
| err_o | output | 1 | One-cycle strobe for an unknown tag |

## Verification
Each tag is driven with an ordinary case and with a case chosen to trip the signed overflow path. This separates the carry rule, which uses an unsigned comparison, from the overflow rule, which uses sign bits. The byte and word compare cases put garbage in the upper operand bits and choose low parts whose flags would differ at full width, so a compare judged at the wrong bit is caught. The extend-chain cases run the same triple with and without chain_i and with both values of the previous zero flag, which confirms that zero can only be cleared. Passthrough words that set N and Z together, and unknown tags sent after a known flag value, cover the two paths that bypass computation.

// File: rtl/cc_eval_pkg.sv
package cc_eval_pkg;
  typedef enum logic [3:0] {
    CC_RESOLVED = 4'd0,
    CC_LOGIC    = 4'd1,
    CC_ADD      = 4'd2,
    CC_SUB      = 4'd3,
    CC_CMP8     = 4'd4,
    CC_CMP16    = 4'd5,
    CC_ADDX     = 4'd6,
    CC_SUBX     = 4'd7,
    CC_SHIFT    = 4'd8
  } cc_op_e;

  localparam int FLAG_W = 5;
  localparam int FC = 0;
  localparam int FV = 1;
  localparam int FZ = 2;
  localparam int FN = 3;
  localparam int FX = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;
endpackage

// File: rtl/cc_nz.sv
module cc_nz #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  output logic         n_o,
  output logic         z_o
);
  assign z_o = (val_i == '0);
  assign n_o = val_i[W-1];
endmodule

// File: rtl/cc_sub_core.sv
module cc_sub_core
  import cc_eval_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic [W-1:0] src_i,
  input  logic         ext_i,
  output nzvc_t        f_o
);
  logic [W-1:0] minuend;
  logic [W-1:0] ovf_vec;
  logic         n_w, z_w;

  // rebuild first operand from saved result and source
  assign minuend = res_i + src_i + {{(W-1){1'b0}}, ext_i};
  assign ovf_vec = (minuend ^ res_i) & (minuend ^ src_i);

  cc_nz #(.W(W)) u_nz (.val_i(res_i), .n_o(n_w), .z_o(z_w));

  always_comb begin
    f_o.n = n_w;
    f_o.z = z_w;
    f_o.v = ovf_vec[W-1];
    f_o.c = ext_i ? (minuend <= src_i) : (minuend < src_i);
  end
endmodule

// File: rtl/cc_add_core.sv
module cc_add_core
  import cc_eval_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic [W-1:0] src_i,
  input  logic         ext_i,
  output nzvc_t        f_o
);
  logic [W-1:0] addend;
  logic [W-1:0] ovf_vec;
  logic         n_w, z_w;

  assign addend  = res_i - src_i - {{(W-1){1'b0}}, ext_i};
  assign ovf_vec = (src_i ^ res_i) & ~(addend ^ src_i);

  cc_nz #(.W(W)) u_nz (.val_i(res_i), .n_o(n_w), .z_o(z_w));

  always_comb begin
    f_o.n = n_w;
    f_o.z = z_w;
    f_o.v = ovf_vec[W-1];
    f_o.c = ext_i ? (res_i <= src_i) : (res_i < src_i);
  end
endmodule

// File: rtl/cc_lazy_eval.sv
module cc_lazy_eval
  import cc_eval_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [FLAG_W-1:0] prev_i,
  input  logic              chain_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;
  localparam int N_SUB  = 3;
  localparam int SUB_W [N_SUB] = '{DATA_W, HALF_W, BYTE_W};

  nzvc_t sub_f [N_SUB];
  nzvc_t add_f;
  nzvc_t nz_f;
  nzvc_t sel_f;
  logic  op_known;
  logic  sticky_z;
  logic  n_res, z_res;

  logic [FLAG_W-1:0] flags_q;
  logic              valid_q, err_q;

  // index 0: full width (sub/subx), 1: word compare, 2: byte compare
  for (genvar g = 0; g < N_SUB; g++) begin : g_sub
    localparam int W = SUB_W[g];
    logic ext_w;
    if (g == 0) begin : g_ext
      assign ext_w = (op_i == CC_SUBX);
    end else begin : g_noext
      assign ext_w = 1'b0;
    end
    cc_sub_core #(.W(W)) u_sub (
      .res_i (res_i[W-1:0]),
      .src_i (src_i[W-1:0]),
      .ext_i (ext_w),
      .f_o   (sub_f[g])
    );
  end

  cc_add_core #(.W(DATA_W)) u_add (
    .res_i (res_i),
    .src_i (src_i),
    .ext_i (op_i == CC_ADDX),
    .f_o   (add_f)
  );

  cc_nz #(.W(DATA_W)) u_nz (.val_i(res_i), .n_o(n_res), .z_o(z_res));

  always_comb begin
    nz_f   = '{n: n_res, z: z_res, v: 1'b0, c: 1'b0};
    sel_f  = nz_f;
    op_known = 1'b1;
    sticky_z = 1'b0;
    unique case (op_i)
      CC_RESOLVED: sel_f = nzvc_t'(res_i[3:0]);
      CC_LOGIC:    sel_f = nz_f;
      CC_ADD, CC_ADDX: begin
        sel_f    = add_f;
        sticky_z = chain_i;
      end
      CC_SUB, CC_SUBX: begin
        sel_f    = sub_f[0];
        sticky_z = chain_i;
      end
      CC_CMP16:    sel_f = sub_f[1];
      CC_CMP8:     sel_f = sub_f[2];
      CC_SHIFT: begin
        sel_f   = nz_f;
        sel_f.c = (src_i != '0);
      end
      default:     op_known = 1'b0;
    endcase
    // zero can only be cleared inside an extended-precision chain
    if (sticky_z) sel_f.z = sel_f.z & prev_i[FZ];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= eval_i && op_known;
      err_q   <= eval_i && !op_known;
      if (eval_i && op_known) flags_q <= {prev_i[FX], sel_f};
    end
  end

  assign flags_o = flags_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> (!valid_o && !err_o && $stable(flags_o)));

  // R2
  nz_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && op_i != 4'd0 && op_i <= 4'd8) |=> !(flags_o[FN] && flags_o[FZ]));

  // R2
  logic_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && op_i == 4'd1) |=> (flags_o[1:0] == 2'b00));

  // R8
  shift_cv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && op_i == 4'd8) |=> (!flags_o[FV] && flags_o[FC] == ($past(src_i) != '0)));

  // R9
  sticky_z_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && chain_i && !prev_i[FZ] &&
     (op_i == 4'd2 || op_i == 4'd3 || op_i == 4'd6 || op_i == 4'd7)) |=> !flags_o[FZ]);

  // R10
  passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && op_i == 4'd0) |=> (flags_o[3:0] == $past(res_i[3:0])));

  // R11
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && op_i > 4'd8) |=> (err_o && !valid_o && $stable(flags_o)));

  // R12
  x_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && op_i <= 4'd8) |=> (valid_o && !err_o && flags_o[FX] == $past(prev_i[FX])));

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));
endmodule

// File: tb/sim_cc_lazy_eval.sv
`timescale 1ns/1ps
module sim_cc_lazy_eval;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        eval_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] res_i = '0;
  logic [31:0] src_i = '0;
  logic [4:0]  prev_i = '0;
  logic        chain_i = 1'b0;
  logic [4:0]  flags_o;
  logic        valid_o, err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  cc_lazy_eval u0 (
    .clk_i, .rst_ni, .eval_i, .op_i, .res_i, .src_i,
    .prev_i, .chain_i, .flags_o, .valid_o, .err_o
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] res;
    logic [31:0] src;
    logic [4:0]  prev;
    logic        chain;
    logic [4:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  // flag word {X,N,Z,V,C}
  localparam vec_t VECS [NV] = '{
    {4'd1, 32'h8000_0000, 32'h0000_0055, 5'h1F, 1'b0, 5'h18, 4'd2},  // R2 logic N, X kept
    {4'd1, 32'h0000_0000, 32'hFFFF_FFFF, 5'h00, 1'b0, 5'h04, 4'd2},  // R2 logic Z
    {4'd2, 32'h0000_0005, 32'h0000_0007, 5'h00, 1'b0, 5'h01, 4'd3},  // R3 add carry
    {4'd2, 32'h8000_0000, 32'h0000_0001, 5'h00, 1'b0, 5'h0A, 4'd3},  // R3 add overflow
    {4'd3, 32'hFFFF_FFFE, 32'h0000_0005, 5'h00, 1'b0, 5'h09, 4'd4},  // R4 sub borrow
    {4'd3, 32'h7FFF_FFFF, 32'h0000_0001, 5'h00, 1'b0, 5'h02, 4'd4},  // R4 sub overflow
    {4'd3, 32'h0000_0000, 32'h0000_1234, 5'h10, 1'b0, 5'h14, 4'd4},  // R4 sub equal
    {4'd4, 32'hABCD_EFF0, 32'h1234_5620, 5'h00, 1'b0, 5'h09, 4'd5},  // R5 byte cmp
    {4'd4, 32'hFFFF_0000, 32'h0000_0080, 5'h00, 1'b0, 5'h04, 4'd5},  // R5 byte zero
    {4'd5, 32'h5555_7FFF, 32'hAAAA_0001, 5'h00, 1'b0, 5'h02, 4'd5},  // R5 word ovf
    {4'd6, 32'h0000_0000, 32'h0000_0000, 5'h00, 1'b0, 5'h05, 4'd6},  // R6 addx
    {4'd6, 32'h0000_0000, 32'h0000_0000, 5'h00, 1'b1, 5'h01, 4'd9},  // R9 addx chain clear
    {4'd6, 32'h0000_0000, 32'h0000_0000, 5'h04, 1'b1, 5'h05, 4'd9},  // R9 addx chain keep
    {4'd7, 32'hFFFF_FFFF, 32'h0000_0005, 5'h00, 1'b0, 5'h09, 4'd7},  // R7 subx
    {4'd7, 32'h0000_0000, 32'h0000_0000, 5'h04, 1'b1, 5'h04, 4'd9},  // R9 subx chain keep
    {4'd7, 32'h0000_0000, 32'h0000_0000, 5'h10, 1'b1, 5'h10, 4'd9},  // R9 subx chain clear
    {4'd8, 32'h0000_0000, 32'h0000_0003, 5'h00, 1'b0, 5'h05, 4'd8},  // R8 shift
    {4'd8, 32'h8000_0001, 32'h0000_0000, 5'h1F, 1'b0, 5'h18, 4'd8},  // R8 shift N
    {4'd0, 32'h0000_000C, 32'hFFFF_FFFF, 5'h10, 1'b0, 5'h1C, 4'd10}, // R10 pass N+Z
    {4'd0, 32'hFFFF_FFF3, 32'h0000_0000, 5'h00, 1'b0, 5'h03, 4'd10}, // R10 pass V+C
    {4'd2, 32'h0000_0000, 32'h0000_0000, 5'h10, 1'b1, 5'h10, 4'd9},  // R9 add chain
    {4'd2, 32'h0000_0000, 32'h0000_0000, 5'h04, 1'b1, 5'h04, 4'd9},  // R9 add chain keep
    {4'd1, 32'h0000_0001, 32'h0000_0000, 5'h10, 1'b0, 5'h10, 4'd12}  // R12 X copy
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] res, input logic [31:0] src,
                       input logic [4:0] prev, input logic chain);
    eval_i = 1'b1; op_i = op; res_i = res; src_i = src; prev_i = prev; chain_i = chain;
    @(posedge clk_i);
    @(negedge clk_i);
    eval_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 flags", 32'(flags_o), 32'h0);
    check("R1 valid", 32'(valid_o), 32'h0);
    check("R1 err", 32'(err_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 flags after release", 32'(flags_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].res, VECS[i].src, VECS[i].prev, VECS[i].chain);
      n_chk++;
      if (flags_o !== VECS[i].exp || valid_o !== 1'b1 || err_o !== 1'b0) begin
        n_fail++;
        $display("FAIL R%0d vec %0d: actual %0h/%0b/%0b expected %0h/1/0",
                 VECS[i].req, i, flags_o, valid_o, err_o, VECS[i].exp);
      end
    end

    // R12 strobe lasts one cycle, R1 idle holds flags
    @(negedge clk_i);
    check("R12 valid drops", 32'(valid_o), 32'h0);
    check("R1 idle hold", 32'(flags_o), 32'h10);

    // R11 unknown tags leave flags alone
    drive(4'd2, 32'h8000_0000, 32'h1, 5'h1F, 1'b0);
    check("R3 setup", 32'(flags_o), 32'h1A);
    drive(4'd9, 32'h0, 32'h0, 5'h00, 1'b0);
    check("R11 err tag 9", 32'(err_o), 32'h1);
    check("R11 valid tag 9", 32'(valid_o), 32'h0);
    check("R11 flags tag 9", 32'(flags_o), 32'h1A);
    drive(4'd15, 32'h0, 32'h0, 5'h00, 1'b1);
    check("R11 err tag 15", 32'(err_o), 32'h1);
    check("R11 flags tag 15", 32'(flags_o), 32'h1A);
    @(negedge clk_i);
    check("R11 err drops", 32'(err_o), 32'h0);

    // R5 upper bits ignored: same low byte, different upper bits
    drive(4'd4, 32'h0000_00F0, 32'hFFFF_FF20, 5'h00, 1'b0);
    check("R5 byte upper ignored", 32'(flags_o), 32'h09);

    // R1 reset in mid-run clears the register
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", 32'(flags_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule